// File: doc/BRIEF.md
# PTP Event Timestamp Capture Channel

This block serves one Ethernet port and takes hardware timestamps of PTP event messages. When the MAC signals that a frame has reached its timestamp point, the channel copies the current system time into a snapshot register. Transmit and receive each have their own snapshot register. The system time arrives on an input as a 64-bit count of 16 ns ticks. On receive the channel also stores the sender's 48-bit source UUID and the 16-bit sequence ID, so that software can match the stored time to the frame it has just taken from the receive queue.

A capture happens only when the message class qualifies. A master-mode bit selects which exchange is stamped. In slave mode the channel stamps received Sync and transmitted Delay_Req messages. In master mode it stamps received Delay_Req and transmitted Sync messages. A second control bit makes the channel stamp every message class in both directions. A stored snapshot sets a lock flag. While the flag is set, further strobes of that direction are ignored. Software reads the words, then clears the flag by writing 1 to its event bit.

Software reaches the channel through a simple word-addressed register bus. Writes take effect on the clock edge. Reads return data combinationally from the address.

Top module: `ts_capture_channel`

## Requirements
- R1: After reset every register reads zero: control, event, both snapshots and both identity words.
- R2: The control word at offset 0x0 holds master mode in bit 0 and stamp-all in bit 1. Both bits are written and read back. Bits 31:2 read zero.
- R3: Receive qualification uses class codes 0 = Sync, 1 = Delay_Req, 2 = Follow_Up and 3 = other. With stamp-all clear, slave mode captures only received Sync and master mode captures only received Delay_Req. A strobe for any other class leaves the event word and the receive snapshot unchanged.
- R4: Transmit qualification uses the same class codes. With stamp-all clear, slave mode captures only transmitted Delay_Req and master mode captures only transmitted Sync.
- R5: With stamp-all set, a strobe of any class code captures in either direction, whatever the master-mode bit is.
- R6: A capture stores the system time present in the cycle of the strobe. The lock flag first reads as set one cycle later. Event bit 0 is the transmit lock and event bit 1 is the receive lock. Both sit in the event word at offset 0x4.
- R7: While a lock flag is set, further strobes of that direction are ignored. The stored time and identity stay unchanged, and the lock stays set.
- R8: Writing 1 to an event bit clears that lock. Writing 0 leaves it unchanged. Clearing one direction does not affect the other.
- R9: If a write-1 clear and a qualifying strobe of the same direction fall in the same cycle, the capture wins. The lock stays set and the snapshot holds the new time.
- R10: A receive capture stores the identity with it. Offset 0x18 holds UUID bits 31:0. Offset 0x1C holds UUID bits 47:32 in bits 15:0 and the sequence ID in bits 31:16.
- R11: The transmit snapshot low and high words are at offsets 0x8 and 0xC. The receive snapshot low and high words are at offsets 0x10 and 0x14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write enable, qualified by bus_sel |
| bus_addr | input | 5 | Byte offset; bits 4:2 pick the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| sys_time | input | 64 | Running system time in 16 ns ticks |
| tx_strobe | input | 1 | Transmit frame at its timestamp point |
| tx_class | input | 2 | Class of the transmitted message |
| rx_strobe | input | 1 | Receive frame at its timestamp point |
| rx_class | input | 2 | Class of the received message |
| rx_uuid | input | 48 | Source UUID of the received message |
| rx_seq | input | 16 | Sequence ID of the received message |

## Verification
A lock flag stuck high shows up in the next qualifying strobe: that strobe is dropped, and a read of the snapshot still returns the previous time. A lock flag stuck low shows up in the following strobe, which overwrites the snapshot before software has read it. A fault in class qualification shows up at once. After a single strobe of the wrong class, a read of the event word shows a set bit where none is expected. A capture that lands one cycle late stores a different time value. The bench changes sys_time on every strobe, so that error appears in the very next snapshot read.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;

  typedef enum logic [1:0] {
    MSG_SYNC   = 2'd0,
    MSG_DREQ   = 2'd1,
    MSG_FOLLOW = 2'd2,
    MSG_OTHER  = 2'd3
  } msg_class_e;

  localparam int unsigned WORD_W = 32;

  // Word indices (byte offset / 4)
  localparam logic [2:0] WI_CTRL  = 3'd0;
  localparam logic [2:0] WI_EVENT = 3'd1;
  localparam logic [2:0] WI_TX_LO = 3'd2;
  localparam logic [2:0] WI_TX_HI = 3'd3;
  localparam logic [2:0] WI_RX_LO = 3'd4;
  localparam logic [2:0] WI_RX_HI = 3'd5;
  localparam logic [2:0] WI_ID_LO = 3'd6;
  localparam logic [2:0] WI_ID_HI = 3'd7;

  // Direction index used by the generate loop
  localparam int unsigned DIR_TX = 0;
  localparam int unsigned DIR_RX = 1;

  // Which class a direction stamps in a given mode.
  function automatic logic class_wanted(input logic master, input logic stamp_all,
                                        input logic is_rx, input msg_class_e cls);
    msg_class_e target;
    if (is_rx) target = master ? MSG_DREQ : MSG_SYNC;
    else       target = master ? MSG_SYNC : MSG_DREQ;
    return stamp_all || (cls == target);
  endfunction

  // Accept rule: a free slot, or one freed in the same cycle.
  function automatic logic slot_accepts(input logic strobe, input logic wanted,
                                        input logic locked, input logic clr);
    return strobe && wanted && (!locked || clr);
  endfunction

endpackage

// File: rtl/ts_cap_qualify.sv
module ts_cap_qualify
  import ts_cap_pkg::*;
#(
  parameter bit IS_RX = 1'b0
) (
  input  logic       master,
  input  logic       stamp_all,
  input  logic [1:0] cls,
  output logic       wanted
);

  always_comb begin
    wanted = class_wanted(master, stamp_all, IS_RX, msg_class_e'(cls));
  end

endmodule

// File: rtl/ts_cap_slot.sv
module ts_cap_slot
  import ts_cap_pkg::*;
#(
  parameter int unsigned TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic              wanted,
  input  logic              clr,
  input  logic [TIME_W-1:0] cap_time,
  output logic              accept,
  output logic              locked,
  output logic [TIME_W-1:0] time_q
);

  assign accept = slot_accepts(strobe, wanted, locked, clr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked <= 1'b0;
      time_q <= '0;
    end else if (accept) begin
      locked <= 1'b1;
      time_q <= cap_time;
    end else if (clr) begin
      locked <= 1'b0;
    end
  end

  // R6
  capture_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (locked && time_q == $past(cap_time)));

  // R7
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !clr) |=> (locked && $stable(time_q)));

  // R8
  clear_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !accept) |=> !locked);

  // R9
  race_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && strobe && wanted) |=> locked);

endmodule

// File: rtl/ts_cap_regs.sv
module ts_cap_regs
  import ts_cap_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              master,
  output logic              stamp_all,
  output logic [1:0]        clr,
  input  logic [1:0]        locked,
  input  logic [63:0]       tx_time,
  input  logic [63:0]       rx_time,
  input  logic [63:0]       rx_ident
);

  logic [2:0] widx;
  logic       wr_ctrl;
  logic       wr_event;
  logic       unused_bits;

  assign widx        = bus_addr[4:2];
  assign wr_ctrl     = bus_sel && bus_wr && (widx == WI_CTRL);
  assign wr_event    = bus_sel && bus_wr && (widx == WI_EVENT);
  assign clr         = wr_event ? bus_wdata[1:0] : 2'b00;
  assign unused_bits = ^{bus_wdata[WORD_W-1:2], bus_addr[1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      master    <= 1'b0;
      stamp_all <= 1'b0;
    end else if (wr_ctrl) begin
      master    <= bus_wdata[0];
      stamp_all <= bus_wdata[1];
    end
  end

  always_comb begin
    case (widx)
      WI_CTRL:  bus_rdata = {30'd0, stamp_all, master};
      WI_EVENT: bus_rdata = {30'd0, locked[DIR_RX], locked[DIR_TX]};
      WI_TX_LO: bus_rdata = tx_time[31:0];
      WI_TX_HI: bus_rdata = tx_time[63:32];
      WI_RX_LO: bus_rdata = rx_time[31:0];
      WI_RX_HI: bus_rdata = rx_time[63:32];
      WI_ID_LO: bus_rdata = rx_ident[31:0];
      default:  bus_rdata = rx_ident[63:32];
    endcase
  end

  // R2
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> ({stamp_all, master} == $past(bus_wdata[1:0])));

endmodule

// File: rtl/ts_capture_channel.sv
module ts_capture_channel
  import ts_cap_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned TIME_W = 64,
  parameter int unsigned UUID_W = 48,
  parameter int unsigned SEQ_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [TIME_W-1:0] sys_time,
  input  logic              tx_strobe,
  input  logic [1:0]        tx_class,
  input  logic              rx_strobe,
  input  logic [1:0]        rx_class,
  input  logic [UUID_W-1:0] rx_uuid,
  input  logic [SEQ_W-1:0]  rx_seq
);

  localparam int unsigned ID_W = UUID_W + SEQ_W;
  localparam int unsigned NDIR = 2;

  logic              master, stamp_all;
  logic [NDIR-1:0]   clr, locked, accept, wanted, strobe_v;
  logic [1:0]        cls_v [NDIR];
  logic [TIME_W-1:0] time_v [NDIR];
  logic [ID_W-1:0]   ident_q;

  assign strobe_v[DIR_TX] = tx_strobe;
  assign strobe_v[DIR_RX] = rx_strobe;
  assign cls_v[DIR_TX]    = tx_class;
  assign cls_v[DIR_RX]    = rx_class;

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    ts_cap_qualify #(.IS_RX(d == DIR_RX)) i_qual (
      .master    (master),
      .stamp_all (stamp_all),
      .cls       (cls_v[d]),
      .wanted    (wanted[d])
    );
    ts_cap_slot #(.TIME_W(TIME_W)) i_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe   (strobe_v[d]),
      .wanted   (wanted[d]),
      .clr      (clr[d]),
      .cap_time (sys_time),
      .accept   (accept[d]),
      .locked   (locked[d]),
      .time_q   (time_v[d])
    );
  end

  // Receive identity rides with the receive capture.
  always_ff @(posedge clk) begin
    if (!rst_n)                ident_q <= '0;
    else if (accept[DIR_RX])   ident_q <= {rx_seq, rx_uuid};
  end

  ts_cap_regs #(.ADDR_W(ADDR_W)) i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .master    (master),
    .stamp_all (stamp_all),
    .clr       (clr),
    .locked    (locked),
    .tx_time   (64'(time_v[DIR_TX])),
    .rx_time   (64'(time_v[DIR_RX])),
    .rx_ident  (64'(ident_q))
  );

  // R10
  ident_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept[DIR_RX] |=> (ident_q == $past({rx_seq, rx_uuid})));

  // R7
  ident_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked[DIR_RX] && !clr[DIR_RX]) |=> $stable(ident_q));

  // R3
  rx_qualify_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept[DIR_RX] && !stamp_all) |->
      (rx_class == (master ? 2'd1 : 2'd0)));

  // R4
  tx_qualify_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept[DIR_TX] && !stamp_all) |->
      (tx_class == (master ? 2'd0 : 2'd1)));

endmodule

// File: tb/test_ts_capture_channel.sv
`timescale 1ns/1ps
module test_ts_capture_channel;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] sys_time = '0;
  logic        tx_strobe = 1'b0, rx_strobe = 1'b0;
  logic [1:0]  tx_class = '0, rx_class = '0;
  logic [47:0] rx_uuid = '0;
  logic [15:0] rx_seq = '0;

  int vectors = 0;
  int errors  = 0;

  always #10 clk = ~clk;

  ts_capture_channel i_ts_capture_channel (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sys_time(sys_time), .tx_strobe(tx_strobe), .tx_class(tx_class),
    .rx_strobe(rx_strobe), .rx_class(rx_class), .rx_uuid(rx_uuid), .rx_seq(rx_seq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  // All drive tasks are called at a falling edge.
  task automatic set_wr(input logic [4:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic set_rx(input logic [1:0] c, input logic [47:0] u,
                        input logic [15:0] s, input logic [63:0] t);
    rx_strobe = 1'b1; rx_class = c; rx_uuid = u; rx_seq = s; sys_time = t;
  endtask

  task automatic set_tx(input logic [1:0] c, input logic [63:0] t);
    tx_strobe = 1'b1; tx_class = c; sys_time = t;
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; rx_strobe = 1'b0; tx_strobe = 1'b0;
    sys_time = sys_time + 64'd7;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    set_wr(a, d);
    tick();
  endtask

  task automatic check_rd(input string tag, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 8; i++) check_rd("R1 reset value", 5'(i * 4), 32'h0);
  endtask

  task automatic t_control;
    wr(5'h00, 32'hFFFF_FFFF);
    check_rd("R2 control all ones", 5'h00, 32'h3);
    wr(5'h00, 32'h0000_0001);
    check_rd("R2 control master only", 5'h00, 32'h1);
    wr(5'h00, 32'h0);
    check_rd("R2 control cleared", 5'h00, 32'h0);
  endtask

  task automatic t_rx_slave;
    set_rx(2'd1, 48'hAAAA_1111_2222, 16'h0101, 64'h1);
    tick();
    check_rd("R3 slave ignores rx Delay_Req", 5'h04, 32'h0);
    check_rd("R3 slave rx snapshot untouched", 5'h10, 32'h0);
    set_rx(2'd0, 48'hBEEF_1234_5678, 16'hC0DE, 64'h0000_0123_89AB_CDEF);
    check_rd("R6 lock not yet visible in strobe cycle", 5'h04, 32'h0);
    tick();
    check_rd("R6 rx lock visible next cycle", 5'h04, 32'h2);
    check_rd("R11 rx snapshot low", 5'h10, 32'h89AB_CDEF);
    check_rd("R11 rx snapshot high", 5'h14, 32'h0000_0123);
    check_rd("R10 uuid low word", 5'h18, 32'h1234_5678);
    check_rd("R10 seq and uuid high", 5'h1C, 32'hC0DE_BEEF);
  endtask

  task automatic t_lock_and_clear;
    set_rx(2'd0, 48'h0000_9999_9999, 16'h7777, 64'h5555_0000_6666);
    tick();
    check_rd("R7 locked rx time kept", 5'h10, 32'h89AB_CDEF);
    check_rd("R7 locked identity kept", 5'h1C, 32'hC0DE_BEEF);
    check_rd("R7 lock still set", 5'h04, 32'h2);
    wr(5'h04, 32'h0);
    check_rd("R8 write zero keeps lock", 5'h04, 32'h2);
    wr(5'h04, 32'h1);
    check_rd("R8 tx clear leaves rx lock", 5'h04, 32'h2);
    wr(5'h04, 32'h2);
    check_rd("R8 rx lock cleared", 5'h04, 32'h0);
  endtask

  task automatic t_tx_modes;
    set_tx(2'd0, 64'h10);
    tick();
    check_rd("R4 slave ignores tx Sync", 5'h04, 32'h0);
    set_tx(2'd1, 64'hFEDC_BA98_7654_3210);
    tick();
    check_rd("R4 slave tx Delay_Req locks", 5'h04, 32'h1);
    check_rd("R11 tx snapshot low", 5'h08, 32'h7654_3210);
    check_rd("R11 tx snapshot high", 5'h0C, 32'hFEDC_BA98);
    wr(5'h00, 32'h1);
    wr(5'h04, 32'h3);
    set_tx(2'd1, 64'h20);
    set_rx(2'd0, 48'h1, 16'h1, 64'h20);
    tick();
    check_rd("R3 R4 master ignores rx Sync and tx Delay_Req", 5'h04, 32'h0);
    set_tx(2'd0, 64'h0000_0042_0000_0099);
    set_rx(2'd1, 48'h0102_0304_0506, 16'h0A0B, 64'h0000_0042_0000_0099);
    tick();
    check_rd("R3 R4 master stamps both", 5'h04, 32'h3);
    check_rd("R4 master tx time", 5'h08, 32'h0000_0099);
    check_rd("R3 master rx identity", 5'h1C, 32'h0A0B_0102);
    wr(5'h04, 32'h3);
  endtask

  task automatic t_stamp_all;
    wr(5'h00, 32'h2);
    set_rx(2'd2, 48'h0, 16'h0, 64'h333);
    set_tx(2'd3, 64'h333);
    tick();
    check_rd("R5 stamp-all captures odd classes", 5'h04, 32'h3);
    check_rd("R5 rx time", 5'h10, 32'h333);
    wr(5'h04, 32'h3);
    wr(5'h00, 32'h3);
    set_rx(2'd0, 48'h0, 16'h0, 64'h444);
    tick();
    check_rd("R5 stamp-all with master keeps Sync", 5'h04, 32'h2);
  endtask

  task automatic t_race;
    // rx lock is set from the stamp-all test with time 0x444
    set_wr(5'h04, 32'h2);
    set_rx(2'd0, 48'hABCD_0000_0001, 16'h0042, 64'h0000_0007_0000_0888);
    tick();
    check_rd("R9 capture wins over clear", 5'h04, 32'h2);
    check_rd("R9 fresh rx time", 5'h10, 32'h0000_0888);
    check_rd("R9 fresh identity", 5'h1C, 32'h0042_ABCD);
  endtask

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_control();
    t_rx_slave();
    t_lock_and_clear();
    t_tx_modes();
    t_stamp_all();
    t_race();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    vectors++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule